// File: doc/BRIEF.md
# Decade Counter with Seven-Segment Drive

This block counts clock edges from 0 to 9 and back, and turns the current digit straight into seven active-high segment lines meant for a common-cathode display. One instance drives one digit. A chain of digits is built by feeding the carry output of one instance to the clock of the next, and by passing the display-enable signal along through each instance's display-enable output.

The display can be blanked with the display-enable input. Blanking turns off the gated segments only; counting carries on underneath. A separate copy of segment c is never blanked. Reset is synchronous. It returns the count to 0 and wins over the hold input. The hold input freezes the count while it is high.

The block has no data stream, so it has no valid/ready interface. All pins are plain control and status lines, and the segment and carry outputs follow the count register with no handshake.

Top module: `decade_seg_counter`

## Requirements
- R1: On each rising clock edge with `rst` low and `hold` low, the count rises by one.
- R2: From count 9 the next counting edge gives count 0.
- R3: `rst` high at a rising edge sets the count to 0, whatever the value of `hold`.
- R4: While `hold` is high (and `rst` low), the count does not change at clock edges.
- R5: `seg` is active high with bit 0 = a, bit 1 = b, up to bit 6 = g. For digits 0..9 it shows 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R6: While `disp_en_in` is low, all seven bits of `seg` are 0. Blanking has no effect on the count, which is seen on `seg` once `disp_en_in` returns high.
- R7: `seg_c_raw` always equals the segment-c value of the current digit (low only for digit 2), whatever the value of `disp_en_in`.
- R8: `disp_en_out` is a combinational copy of `disp_en_in`.
- R9: `carry` is high for counts 0..4 and low for counts 5..9, so it rises once per completed decade.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to count 0, active high |
| hold | input | 1 | High freezes the count |
| disp_en_in | input | 1 | High shows the digit, low blanks `seg` |
| seg | output | 7 | Gated segments a..g, bit 0 = a |
| seg_c_raw | output | 1 | Segment c, never blanked |
| disp_en_out | output | 1 | Copy of `disp_en_in` for the next digit |
| carry | output | 1 | High for counts 0..4, low for 5..9 |

## Verification
Several functions can act in the same cycle. The decade wrap, when the carry rises, can fall in a cycle where the display is blanked. In that cycle `seg` must be zero while `carry` and `seg_c_raw` still follow the new count. Reset can also meet hold in one edge, and reset must win. The bench provokes both by toggling `disp_en_in` every cycle through several wraps, and by raising `rst` together with `hold` in the middle of a count. A scoreboard model, built only from the requirements, judges every output after each edge.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int SEG_N = 7;
  typedef logic [SEG_N-1:0] seg_t;

  // Active-high pattern, bit 0 = a ... bit 6 = g
  function automatic seg_t digit_pattern(input logic [3:0] d);
    seg_t s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dsc_count.sv
module dsc_count #(
  parameter int MODULUS = 10,
  localparam int CW = $clog2(MODULUS),
  localparam int LAST = MODULUS - 1,
  localparam int HALF = MODULUS / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  output logic [CW-1:0] cnt,
  output logic          carry
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!hold)
      cnt <= (cnt == CW'(LAST)) ? '0 : cnt + CW'(1);
  end

  assign carry = (cnt < CW'(HALF));

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!hold && cnt != CW'(LAST)) |=> (cnt == $past(cnt) + CW'(1)));
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!hold && cnt == CW'(LAST)) |=> (cnt == '0));
  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cnt));
  p_carry_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (!hold && cnt == CW'(LAST)) |=> carry);
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LAST));
endmodule

// File: rtl/dsc_decode.sv
module dsc_decode
  import dsc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cnt,
  output seg_t          seg_raw
);
  always_comb seg_raw = digit_pattern(4'(cnt));
endmodule

// File: rtl/dsc_gate.sv
module dsc_gate
  import dsc_pkg::*;
(
  input  seg_t seg_raw,
  input  logic en,
  output seg_t seg_out
);
  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign seg_out[i] = seg_raw[i] & en;
  end
endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
  import dsc_pkg::*;
#(
  parameter int MODULUS = 10,
  localparam int CW = $clog2(MODULUS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       disp_en_in,
  output logic [6:0] seg,
  output logic       seg_c_raw,
  output logic       disp_en_out,
  output logic       carry
);
  logic [CW-1:0] cnt;
  seg_t          seg_raw;

  dsc_count #(.MODULUS(MODULUS)) u_count (
    .clk(clk), .rst(rst), .hold(hold), .cnt(cnt), .carry(carry)
  );

  dsc_decode #(.CW(CW)) u_decode (.cnt(cnt), .seg_raw(seg_raw));

  dsc_gate u_gate (.seg_raw(seg_raw), .en(disp_en_in), .seg_out(seg));

  assign seg_c_raw   = seg_raw[2];
  assign disp_en_out = disp_en_in;

  p_blank_r6: assert property (@(posedge clk) disable iff (rst)
    !disp_en_in |-> (seg == '0));
  p_ungated_r7: assert property (@(posedge clk) disable iff (rst)
    disp_en_in |-> (seg[2] == seg_c_raw));
  p_c_off_only_two_r7: assert property (@(posedge clk) disable iff (rst)
    !seg_c_raw |-> (cnt == CW'(2)));
endmodule

// File: tb/decade_seg_counter_bench.sv
`timescale 1ns/1ps
module decade_seg_counter_bench;
  typedef struct {
    logic [6:0] seg;
    logic       craw;
    logic       den;
    logic       carry;
    string      tag;
  } item_t;

  logic clk = 0, rst = 1, hold = 0, en = 1;
  logic [6:0] seg;
  logic seg_c_raw, disp_en_out, carry;
  int checks = 0, errors = 0;
  int model = 0;
  item_t q[$];
  string tag = "R3";
  bit done = 0;

  always #2.5 clk = ~clk;

  decade_seg_counter u_decade_seg_counter (
    .clk(clk), .rst(rst), .hold(hold), .disp_en_in(en),
    .seg(seg), .seg_c_raw(seg_c_raw), .disp_en_out(disp_en_out), .carry(carry)
  );

  function automatic logic [6:0] pat(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic cyc(input logic r, input logic h, input logic e);
    item_t it;
    @(negedge clk);
    rst = r; hold = h; en = e;
    @(posedge clk);
    if (r) model = 0;
    else if (!h) model = (model == 9) ? 0 : model + 1;
    it.seg = e ? pat(model) : 7'h00;
    it.craw = pat(model) >> 2;
    it.den = e;
    it.carry = (model < 5);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cmp(input string req, input logic [6:0] a, input logic [6:0] x);
    checks++;
    if (a !== x) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, a, x);
    end
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        cmp({it.tag, "/R5/R6 seg"}, seg, it.seg);
        cmp({it.tag, "/R7 seg_c_raw"}, 7'(seg_c_raw), 7'(it.craw));
        cmp({it.tag, "/R8 disp_en_out"}, 7'(disp_en_out), 7'(it.den));
        cmp({it.tag, "/R9 carry"}, 7'(carry), 7'(it.carry));
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3: reset with hold high still clears; reset state
    tag = "R3";
    cyc(1, 1, 1); cyc(1, 0, 1);
    // R1 R2 R5 R9: free count over multiple decades
    tag = "R1_R2";
    for (int i = 0; i < 25; i++) cyc(0, 0, 1);
    // R4: hold freezes
    tag = "R4";
    for (int i = 0; i < 5; i++) cyc(0, 1, 1);
    // R6 R7 R8: blanked while counting, then shown again
    tag = "R6";
    for (int i = 0; i < 13; i++) cyc(0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);
    // blanking during hold
    for (int i = 0; i < 3; i++) cyc(0, 1, 0);
    cyc(0, 1, 1);
    // R3 mid-count with hold high
    tag = "R3";
    cyc(0, 0, 1); cyc(1, 1, 0); cyc(0, 1, 1);
    // enable toggled every cycle through wraps (carry rise while blanked)
    tag = "R9";
    for (int i = 0; i < 30; i++) cyc(0, 0, logic'(i % 2));
    @(posedge clk); #3;
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule